// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the countdown timer of a per-core interrupt controller. Software programs three things through a narrow register write port: a packed timer entry word, an initial count, and a clock divide code. The entry word names the interrupt vector, the delivery mode and the trigger type. It also holds a mask bit and a bit that selects between one-shot and periodic operation. Writing a nonzero initial count loads the live counter and starts it. The counter then steps down once every 2^d clocks.

When the counter runs out, the block raises one interrupt request. The request carries the vector, mode and trigger bit that the entry word holds at that moment. In periodic operation the counter rearms itself from the initial count and keeps running. In one-shot operation it parks at zero. The live count and every programmed register can be read back through a combinational read port. Delivery, prioritisation and address decoding are handled elsewhere.

Top module: `irqt_timer`

## Requirements
- R1: After reset every register reads zero, the timer is stopped, and `req_valid` stays low.
- R2: Select 0 holds the entry word. It stores and returns the vector in bits 7:0, the delivery mode in bits 10:8, polarity in bit 13, remote-IRR status in bit 14, trigger in bit 15, mask in bit 16 and periodic in bit 17. All other bits read as zero.
- R3: A write to select 1 (initial count) with a nonzero value loads the live count in the same edge and starts counting. A write of zero clears the live count and stops the timer. Select 1 reads back the written initial count.
- R4: Select 2 holds a 3-bit divide code d in data bits 2:0, and it reads back. The live count drops by one every 2^d clocks. Writing select 1 or select 2 restarts the divider phase, so an initial count C written at edge E expires at edge E + C*2^d.
- R5: At expiry the block drives `req_valid` high for exactly one cycle. The pulse carries the vector, mode and trigger bit that the entry held at the expiry edge.
- R6: With the periodic bit set, expiry reloads the live count from the initial count, and the next expiry follows C*2^d clocks later.
- R7: With the periodic bit clear, the live count stays at zero after expiry and no further request is raised until select 1 is written again.
- R8: With the mask bit set, expiry raises no request but still reloads (periodic) or stops (one-shot) the counter.
- R9: Select 3 reads the live count. Writes to select 3 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 entry, 1 initial count, 2 divide, 3 live count (read only) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select, same encoding as `wr_sel` |
| rd_data | output | 32 | Combinational readback of the selected register |
| req_valid | output | 1 | One-cycle interrupt request pulse |
| req_vector | output | 8 | Vector of the request |
| req_mode | output | 3 | Delivery mode of the request |
| req_trigger | output | 1 | Trigger-type bit of the request |

## Verification
The checker assumes a single writer that changes registers only through `wr_en`. It assumes that a nonzero live count can only come from an initial-count write or a periodic reload. Its properties are therefore written in terms of write strobes and the live count rather than wall-clock windows. The bench drives all inputs on the falling edge and holds each write for one cycle. It programs the divide code and the entry before the initial count, so every measured latency starts from a known divider phase.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SEL_ENTRY = 2'd0,
        SEL_INIT  = 2'd1,
        SEL_DIV   = 2'd2,
        SEL_CUR   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       periodic;
        logic       mask;
        logic       trigger;
        logic       remote_irr;
        logic       polarity;
        logic [2:0] mode;
        logic [7:0] vector;
    } tmr_entry_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] vector;
        logic [2:0] mode;
        logic       trigger;
    } irq_req_t;

    function automatic tmr_entry_t unpack_entry(input logic [DATA_W-1:0] w);
        tmr_entry_t e;
        e.vector     = w[7:0];
        e.mode       = w[10:8];
        e.polarity   = w[13];
        e.remote_irr = w[14];
        e.trigger    = w[15];
        e.mask       = w[16];
        e.periodic   = w[17];
        return e;
    endfunction

    function automatic logic [DATA_W-1:0] pack_entry(input tmr_entry_t e);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[7:0]   = e.vector;
        w[10:8]  = e.mode;
        w[13]    = e.polarity;
        w[14]    = e.remote_irr;
        w[15]    = e.trigger;
        w[16]    = e.mask;
        w[17]    = e.periodic;
        return w;
    endfunction

endpackage

// File: rtl/irqt_regs.sv
module irqt_regs
    import irqt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    output tmr_entry_t          entry_q,
    output logic [CNT_W-1:0]    init_q,
    output logic [DIV_W-1:0]    div_q,
    output logic                load,
    output logic [CNT_W-1:0]    load_val,
    output logic                restart
);

    logic wr_entry;
    logic wr_init;
    logic wr_div;

    always_comb begin
        wr_entry = wr_en && (reg_sel_e'(wr_sel) == SEL_ENTRY);
        wr_init  = wr_en && (reg_sel_e'(wr_sel) == SEL_INIT);
        wr_div   = wr_en && (reg_sel_e'(wr_sel) == SEL_DIV);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q <= '0;
            init_q  <= '0;
            div_q   <= '0;
        end else begin
            if (wr_entry) entry_q <= unpack_entry(wr_data);
            if (wr_init)  init_q  <= wr_data[CNT_W-1:0];
            if (wr_div)   div_q   <= wr_data[DIV_W-1:0];
        end
    end

    always_comb begin
        load     = wr_init;
        load_val = wr_data[CNT_W-1:0];
        restart  = wr_init || wr_div;
    end

endmodule

// File: rtl/irqt_prescaler.sv
module irqt_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);

    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = '0;
        for (int i = 0; i < PRE_W; i++) begin
            limit[i] = (i < int'(div_code));
        end
        tick = run && (pre_cnt == limit);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_cnt <= '0;
        end else if (run) begin
            pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/irqt_counter.sv
module irqt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] cur_count,
    output logic             running,
    output logic             expire
);

    logic last_step;

    always_comb begin
        last_step = (cur_count <= CNT_W'(1));
        expire    = tick && running && last_step && !load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_count <= '0;
            running   <= 1'b0;
        end else if (load) begin
            cur_count <= load_val;
            running   <= (load_val != '0);
        end else if (expire) begin
            cur_count <= periodic ? init_val : '0;
            running   <= periodic && (init_val != '0);
        end else if (tick && running) begin
            cur_count <= cur_count - 1'b1;
        end
    end

endmodule

// File: rtl/irqt_request.sv
module irqt_request
    import irqt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       expire,
    input  tmr_entry_t entry,
    output irq_req_t   req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= '0;
        end else begin
            req.valid <= expire && !entry.mask;
            if (expire) begin
                req.vector  <= entry.vector;
                req.mode    <= entry.mode;
                req.trigger <= entry.trigger;
            end
        end
    end

endmodule

// File: rtl/irqt_timer.sv
module irqt_timer
    import irqt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    output logic        req_valid,
    output logic [7:0]  req_vector,
    output logic [2:0]  req_mode,
    output logic        req_trigger
);

    tmr_entry_t       entry_q;
    logic [CNT_W-1:0] init_q;
    logic [DIV_W-1:0] div_q;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             restart;
    logic             tick;
    logic [CNT_W-1:0] cur_count;
    logic             running;
    logic             expire;
    irq_req_t         req;

    irqt_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .entry_q  (entry_q),
        .init_q   (init_q),
        .div_q    (div_q),
        .load     (load),
        .load_val (load_val),
        .restart  (restart)
    );

    irqt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .run      (running),
        .div_code (div_q),
        .tick     (tick)
    );

    irqt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_val  (load_val),
        .tick      (tick),
        .periodic  (entry_q.periodic),
        .init_val  (init_q),
        .cur_count (cur_count),
        .running   (running),
        .expire    (expire)
    );

    irqt_request u_req (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .entry  (entry_q),
        .req    (req)
    );

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_ENTRY: rd_data = pack_entry(entry_q);
            SEL_INIT:  rd_data = DATA_W'(init_q);
            SEL_DIV:   rd_data = DATA_W'(div_q);
            default:   rd_data = DATA_W'(cur_count);
        endcase
        req_valid   = req.valid;
        req_vector  = req.vector;
        req_mode    = req.mode;
        req_trigger = req.trigger;
    end

endmodule

// File: rtl/irqt_checker.sv
module irqt_checker
    import irqt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [31:0]      wr_data,
    input logic             req_valid,
    input logic [CNT_W-1:0] cur_count,
    input tmr_entry_t       entry_q
);

    logic init_wr;
    assign init_wr = wr_en && (wr_sel == 2'd1);

    // R1: first cycle out of reset carries no request and a zero count
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!req_valid && cur_count == '0));

    // R3: writing a zero initial count stops the timer
    p_zero_stops_r3: assert property (@(posedge clk) disable iff (rst)
        (init_wr && wr_data == 32'd0) |=> (cur_count == '0 && !req_valid));

    // R4: without a load, the count only holds or drops by one
    p_step_by_one_r4: assert property (@(posedge clk) disable iff (rst)
        (!init_wr && cur_count > CNT_W'(1)) |=>
        (cur_count == $past(cur_count) || cur_count == $past(cur_count) - 1'b1));

    // R5: a request follows a live count of one
    p_req_from_expiry_r5: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ($past(cur_count) == CNT_W'(1) && !$past(init_wr)));

    // R7: a zero count stays zero until the initial count is written
    p_zero_parks_r7: assert property (@(posedge clk) disable iff (rst)
        (cur_count == '0 && !init_wr) |=> cur_count == '0);

    // R8: no request leaves while the mask bit was set at expiry
    p_mask_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !$past(entry_q.mask));

endmodule

bind irqt_timer irqt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .req_valid (req_valid),
    .cur_count (cur_count),
    .entry_q   (entry_q)
);

// File: tb/tb_irqt_timer.sv
`timescale 1ns/1ps
module tb_irqt_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic [1:0]  rd_sel;
    logic [31:0] rd_data;
    logic        req_valid;
    logic [7:0]  req_vector;
    logic [2:0]  req_mode;
    logic        req_trigger;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    irqt_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .req_valid(req_valid),
        .req_vector(req_vector), .req_mode(req_mode), .req_trigger(req_trigger)
    );

    // entry[50:19], divide code [18:16], initial count [15:0]; all one-shot, unmasked
    localparam logic [50:0] VECS [5] = '{
        {32'h0000_0041, 3'd0, 16'd5},
        {32'h0000_8522, 3'd1, 16'd3},
        {32'h0000_03FE, 3'd3, 16'd4},
        {32'h0000_8700, 3'd7, 16'd2},
        {32'h0000_0110, 3'd2, 16'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] val);
        rd_sel = sel;
        #0.5;
        val = rd_data;
    endtask

    task automatic wait_req(input int limit, output int n);
        n = 0;
        while (!req_valid && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic quiet(input int len, input string req);
        int seen = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (req_valid) seen++;
        end
        chk(req, seen, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            chk("R1 readback zero", v, 32'd0);
        end
        quiet(10, "R1 no request");

        // R2: entry field storage
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v);
        chk("R2 entry all ones", v, 32'h0003_E7FF);
        wr(2'd0, 32'h0000_6000);
        rd(2'd0, v);
        chk("R2 polarity/remote", v, 32'h0000_6000);

        // R4/R5/R7: table of one-shot runs
        for (int i = 0; i < 5; i++) begin
            logic [31:0] ent;
            logic [2:0]  dv;
            logic [15:0] cn;
            ent = VECS[i][50:19];
            dv  = VECS[i][18:16];
            cn  = VECS[i][15:0];
            wr(2'd0, ent);
            wr(2'd2, {29'd0, dv});
            rd(2'd2, v);
            chk("R4 divide readback", v, {29'd0, dv});
            wr(2'd1, {16'd0, cn});
            rd(2'd1, v);
            chk("R3 init readback", v, {16'd0, cn});
            rd(2'd3, v);
            chk("R3 load current", v, {16'd0, cn});
            wait_req(5000, n);
            chk("R4 expiry latency", n, int'(cn) << dv);
            chk("R5 vector", {24'd0, req_vector}, {24'd0, ent[7:0]});
            chk("R5 mode", {29'd0, req_mode}, {29'd0, ent[10:8]});
            chk("R5 trigger", {31'd0, req_trigger}, {31'd0, ent[15]});
            @(negedge clk);
            chk("R5 single pulse", {31'd0, req_valid}, 32'd0);
            rd(2'd3, v);
            chk("R7 parked at zero", v, 32'd0);
        end
        quiet(50, "R7 no second request");

        // R6: periodic reload
        wr(2'd0, 32'h0002_0133);
        wr(2'd2, 32'd1);
        wr(2'd1, 32'd4);
        wait_req(1000, n);
        chk("R6 first expiry", n, 8);
        rd(2'd3, v);
        chk("R6 reload value", v, 32'd4);
        chk("R6 vector", {24'd0, req_vector}, 32'h33);
        @(negedge clk);
        chk("R6 pulse ends", {31'd0, req_valid}, 32'd0);
        wait_req(1000, n);
        chk("R6 second expiry", n, 7);

        // R3: zero write stops
        wr(2'd1, 32'd0);
        rd(2'd3, v);
        chk("R3 zero stops count", v, 32'd0);
        quiet(40, "R3 stopped no request");

        // R8: masked periodic keeps reloading, masked one-shot stops
        wr(2'd0, 32'h0003_0055);
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd3);
        quiet(3, "R8 masked periodic");
        rd(2'd3, v);
        chk("R8 masked reload", v, 32'd3);
        quiet(20, "R8 masked periodic later");
        wr(2'd0, 32'h0001_0055);
        wr(2'd1, 32'd3);
        quiet(10, "R8 masked one-shot");
        rd(2'd3, v);
        chk("R8 masked one-shot stops", v, 32'd0);

        // R9: live count is read only
        wr(2'd3, 32'h0000_1234);
        rd(2'd3, v);
        chk("R9 current unchanged", v, 32'd0);
        rd(2'd0, v);
        chk("R9 entry unchanged", v, 32'h0001_0055);
        rd(2'd1, v);
        chk("R9 init unchanged", v, 32'd3);

        // R1: reset mid-run clears everything
        wr(2'd0, 32'h0002_0011);
        wr(2'd1, 32'd9);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(2'd3, v);
        chk("R1 reset clears count", v, 32'd0);
        rd(2'd0, v);
        chk("R1 reset clears entry", v, 32'd0);
        quiet(30, "R1 no request after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule